// File: doc/BRIEF.md
# Header-Phased SPI Transfer Sequencer

This block runs one half-duplex SPI transaction at a time. A transaction may open with up to four header phases, each with its own byte count: an opcode, an address, a read-mode byte field and a stretch of dummy clocks. A data phase follows them. A phase whose count is zero is skipped. In the data phase the block either pops 32-bit words from an external write queue and shifts them out, or shifts in a programmed number of bytes and pushes them as 32-bit words to an external read queue.

A one-cycle `go` pulse starts the transaction and raises `busy`, which is the start flag. A read lowers `busy` by itself once its byte count is done. A write keeps running, and stalls with the clock parked low whenever the queue is empty, until `stop` is seen at a word boundary. The bit rate comes from an external enable, `bit_tick`. Each tick is one half period of SCLK. The header registers, the counts and the mode inputs must stay stable while `busy` is high.

Top module: `spi_hdr_seq`

## Requirements
- R1: After reset, and whenever no transaction is active, `cs_n` is 1, `sclk` is 0, `sd_oe` is 0, `busy` is 0 and `xfer_rdy` is 1.
- R2: `hdr_cnt` holds the phase counts at fixed positions: opcode bytes in bits 1:0, address bytes in bits 6:4, read-mode bytes in bits 9:8 and dummy units in bits 14:12. The phases run as opcode, address, read-mode, dummy and then data. A zero count skips its phase.
- R3: A header phase with count N sends byte N-1 down to byte 0 of its register (byte k is bits 8k+7:8k), most significant bit first. Address byte positions 4 to 6 hold zero.
- R4: Each dummy unit is 8 SCLK cycles. During these cycles `sd_oe` is 0 and the values on `sd_i` are not captured.
- R5: Lane width: the opcode uses a single line. The address and read-mode phases use four lines when `addr_quad`=1 and a single line otherwise. The data phase follows `data_pins`: 00 is single (out on `sd_o[0]`, in on `sd_i[1]`), bit 0 alone is dual (lanes 1:0), and bit 1 is quad (lanes 3:0, taking priority over bit 0). The highest lane carries the most significant bit of each group.
- R6: On a write (`wr_mode`=1) each popped word is sent byte 0 first when `word4`=1. When `word4`=0 only its byte 0 is sent.
- R7: A write continues while `stop` is 0. It stalls with `sclk` low while the queue is empty. It ends only when `stop` is 1 at a word boundary, so a word already started is always sent whole.
- R8: On a read (`wr_mode`=0) the block clocks in `din_cnt` bytes with `sd_oe` 0. With `word4`=1 it packs byte k of each group of four into bits 8k+7:8k. A short final word is zero-filled. With `word4`=0 it pushes each byte in bits 7:0. It then ends by itself, and a count of 0 ends the transaction after the header.
- R9: `busy` rises one cycle after `go` and falls when the transaction ends. `done` pulses for one cycle as `busy` falls. `cs_n` is low exactly while `busy` is high.
- R10: `xfer_rdy` is 1 when idle, or during a write data phase once every popped byte has been sent and the queue is empty. Otherwise it is 0, for example during the header.
- R11: SPI mode 0: `sclk` toggles only on cycles with `bit_tick`, input is sampled as `sclk` rises, and `sd_o` does not change while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Half-period enable for SCLK |
| go | input | 1 | Start pulse |
| stop | input | 1 | Write stop request (level) |
| wr_mode | input | 1 | 1 = write, 0 = read |
| word4 | input | 1 | 1 = 4-byte data words, 0 = 1-byte |
| hdr_cnt | input | 16 | Header phase counts |
| inst_reg | input | 32 | Opcode bytes |
| addr_reg | input | 32 | Address bytes |
| rmode_reg | input | 32 | Read-mode bytes |
| din_cnt | input | CNT_W | Read data byte count |
| data_pins | input | 2 | Data phase lane select |
| addr_quad | input | 1 | Four lanes for address and read-mode phases |
| wf_data | input | 32 | Head word of the write queue |
| wf_empty | input | 1 | Write queue empty |
| wf_pop | output | 1 | Take the head word of the write queue |
| rf_data | output | 32 | Received word |
| rf_push | output | 1 | Received word valid |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| sd_o | output | 4 | Data lane outputs |
| sd_oe | output | 4 | Data lane output enables |
| sd_i | input | 4 | Data lane inputs |
| busy | output | 1 | Start flag |
| xfer_rdy | output | 1 | Idle or write data drained |
| done | output | 1 | End-of-transaction pulse |

## Verification
The assertions check on every cycle that chip select tracks the start flag, that `done` goes with its falling edge, and that the lanes are released during dummy clocks, read data and idle. They also check that SCLK moves only on a tick, that outputs hold while SCLK is high, and that words are taken from the queue only with SCLK low. Only the bench scenarios can show the content of the serial stream. That covers phase order and skipping, byte selection within each register, lane packing for each width, byte order within words, whole-word completion after a late stop, the zero-filled last read word, and dummy-clock input being dropped.

// File: rtl/spi_hdr_seq.sv
module spi_hdr_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             go,
  input  logic             stop,
  input  logic             wr_mode,
  input  logic             word4,
  input  logic [15:0]      hdr_cnt,
  input  logic [31:0]      inst_reg,
  input  logic [31:0]      addr_reg,
  input  logic [31:0]      rmode_reg,
  input  logic [CNT_W-1:0] din_cnt,
  input  logic [1:0]       data_pins,
  input  logic             addr_quad,
  input  logic [31:0]      wf_data,
  input  logic             wf_empty,
  output logic             wf_pop,
  output logic [31:0]      rf_data,
  output logic             rf_push,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       sd_o,
  output logic [3:0]       sd_oe,
  input  logic [3:0]       sd_i,
  output logic             busy,
  output logic             xfer_rdy,
  output logic             done
);

  typedef enum logic [2:0] {S_IDLE, S_INS, S_ADR, S_RMD, S_DMY, S_DAT, S_FIN} st_t;

  st_t             st, nx;
  logic [2:0]      nx_cnt, blft;
  logic            shifting, oe_on;
  logic [7:0]      sh, rbyte;
  logic [3:0]      steps;
  logic [1:0]      lw, wrem, rpos;
  logic [31:0]     wbuf, rword, rnext;
  logic [CNT_W-1:0] rdlft;
  logic [63:0]     hsrc;
  logic [7:0]      hbyte;
  logic [7:0]      rshift;

  wire [1:0] ic = hdr_cnt[1:0];
  wire [2:0] ac = hdr_cnt[6:4];
  wire [1:0] mc = hdr_cnt[9:8];
  wire [2:0] dc = hdr_cnt[14:12];
  wire [1:0] dlw = data_pins[1] ? 2'd2 : (data_pins[0] ? 2'd1 : 2'd0);
  wire [1:0] hlw = addr_quad ? 2'd2 : 2'd0;

  always_comb begin
    nx = S_DAT;     nx_cnt = 3'd0;
    if (st < S_DMY && dc != 0)      begin nx = S_DMY; nx_cnt = dc;         end
    if (st < S_RMD && mc != 0)      begin nx = S_RMD; nx_cnt = {1'b0, mc}; end
    if (st < S_ADR && ac != 0)      begin nx = S_ADR; nx_cnt = ac;         end
    if (st < S_INS && ic != 0)      begin nx = S_INS; nx_cnt = {1'b0, ic}; end
  end

  always_comb begin
    case (st)
      S_INS:   hsrc = {32'd0, inst_reg};
      S_ADR:   hsrc = {32'd0, addr_reg};
      S_RMD:   hsrc = {32'd0, rmode_reg};
      default: hsrc = 64'd0;
    endcase
    hbyte = hsrc[{blft - 3'd1, 3'b000} +: 8];
  end

  always_comb begin
    case (lw)
      2'd0:    begin sd_o = {3'b000, sh[7]};  rshift = {rbyte[6:0], sd_i[1]};   end
      2'd1:    begin sd_o = {2'b00, sh[7:6]}; rshift = {rbyte[5:0], sd_i[1:0]}; end
      default: begin sd_o = sh[7:4];          rshift = {rbyte[3:0], sd_i};      end
    endcase
    if (!oe_on)          sd_oe = 4'h0;
    else if (lw == 2'd2) sd_oe = 4'hF;
    else if (lw == 2'd1) sd_oe = 4'h3;
    else                 sd_oe = 4'h1;
    rnext = word4 ? (rword | ({24'd0, rbyte} << {rpos, 3'b000})) : {24'd0, rbyte};
  end

  wire wr_idle = st == S_DAT && wr_mode && !shifting && wrem == 2'd0;
  assign wf_pop   = wr_idle && !stop && !wf_empty;
  assign xfer_rdy = !busy || (wr_idle && wf_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; blft <= '0; shifting <= 1'b0; oe_on <= 1'b0;
      sh <= '0; rbyte <= '0; steps <= '0; lw <= '0; wrem <= '0; rpos <= '0;
      wbuf <= '0; rword <= '0; rdlft <= '0; rf_data <= '0; rf_push <= 1'b0;
      sclk <= 1'b0; cs_n <= 1'b1; busy <= 1'b0; done <= 1'b0;
    end else begin
      done    <= 1'b0;
      rf_push <= 1'b0;
      if (st == S_IDLE) begin
        if (go) begin
          busy <= 1'b1; cs_n <= 1'b0; st <= nx; blft <= nx_cnt;
          rdlft <= din_cnt; wrem <= '0; rpos <= '0; rword <= '0;
        end
      end else if (st == S_FIN) begin
        busy <= 1'b0; cs_n <= 1'b1; done <= 1'b1; st <= S_IDLE;
      end else if (shifting) begin
        if (bit_tick) begin
          if (!sclk) begin
            sclk  <= 1'b1;
            rbyte <= rshift;
          end else begin
            sclk  <= 1'b0;
            case (lw)
              2'd0:    sh <= sh << 1;
              2'd1:    sh <= sh << 2;
              default: sh <= sh << 4;
            endcase
            steps <= steps - 4'd1;
            if (steps == 4'd1) begin
              shifting <= 1'b0;
              oe_on    <= 1'b0;
              if (st == S_DAT && !wr_mode) begin
                if (!word4 || rpos == 2'd3 || rdlft == '0) begin
                  rf_data <= rnext; rf_push <= 1'b1; rword <= '0; rpos <= '0;
                end else begin
                  rword <= rnext; rpos <= rpos + 2'd1;
                end
              end
            end
          end
        end
      end else begin
        case (st)
          S_INS, S_ADR, S_RMD: begin
            if (blft != 0) begin
              sh <= hbyte; blft <= blft - 3'd1; lw <= (st == S_INS) ? 2'd0 : hlw;
              steps <= 4'd8 >> ((st == S_INS) ? 2'd0 : hlw);
              oe_on <= 1'b1; shifting <= 1'b1;
            end else begin
              st <= nx; blft <= nx_cnt;
            end
          end
          S_DMY: begin
            if (blft != 0) begin
              sh <= '0; blft <= blft - 3'd1; lw <= 2'd0; steps <= 4'd8;
              oe_on <= 1'b0; shifting <= 1'b1;
            end else begin
              st <= nx; blft <= nx_cnt;
            end
          end
          S_DAT: begin
            lw    <= dlw;
            steps <= 4'd8 >> dlw;
            if (wr_mode) begin
              if (wrem != 2'd0) begin
                sh <= wbuf[7:0]; wbuf <= wbuf >> 8; wrem <= wrem - 2'd1;
                oe_on <= 1'b1; shifting <= 1'b1;
              end else if (stop) begin
                st <= S_FIN;
              end else if (!wf_empty) begin
                sh <= wf_data[7:0]; wbuf <= wf_data >> 8; wrem <= word4 ? 2'd3 : 2'd0;
                oe_on <= 1'b1; shifting <= 1'b1;
              end
            end else begin
              if (rdlft != '0) begin
                rdlft <= rdlft - 1'b1; sh <= '0; rbyte <= '0;
                oe_on <= 1'b0; shifting <= 1'b1;
              end else begin
                st <= S_FIN;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_hdr_seq_chk.sv
module spi_hdr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       busy,
  input logic       cs_n,
  input logic       done,
  input logic       sclk,
  input logic [3:0] sd_o,
  input logic [3:0] sd_oe,
  input logic       wf_pop,
  input logic       wr_mode,
  input logic [2:0] st
);
  localparam logic [2:0] PH_DMY = 3'd4;
  localparam logic [2:0] PH_DAT = 3'd5;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && sd_oe == 4'h0));

  p_dummy_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_DMY) |-> sd_oe == 4'h0);

  p_pop_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wf_pop |-> !sclk);

  p_read_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_DAT && !wr_mode) |-> sd_oe == 4'h0);

  p_cs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n != busy);

  p_done_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(sclk));

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sd_o));
endmodule

bind spi_hdr_seq spi_hdr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .busy(busy), .cs_n(cs_n),
  .done(done), .sclk(sclk), .sd_o(sd_o), .sd_oe(sd_oe), .wf_pop(wf_pop),
  .wr_mode(wr_mode), .st(st)
);

// File: tb/spi_hdr_seq_test.sv
module spi_hdr_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic go = 0, stop = 0, wr_mode = 1, word4 = 1, addr_quad = 0;
  logic [15:0] hdr_cnt = '0;
  logic [31:0] inst_reg = '0, addr_reg = '0, rmode_reg = '0;
  logic [15:0] din_cnt = '0;
  logic [1:0] data_pins = '0;
  logic [31:0] wf_data, rf_data;
  logic wf_empty, wf_pop, rf_push, sclk, cs_n, busy, xfer_rdy, done, bit_tick;
  logic [3:0] sd_o, sd_oe, sd_i;

  logic [1:0] tc = '0;
  always @(posedge clk) tc <= tc + 2'd1;
  assign bit_tick = tc[0];

  logic [31:0] wq [4];
  int wq_n = 0, wq_rd = 0;
  assign wf_empty = (wq_rd >= wq_n);
  assign wf_data  = wq[wq_rd[1:0]];
  always @(posedge clk) if (wf_pop) wq_rd <= wq_rd + 1;

  logic [3:0] src [128];
  int rc = 0;
  assign sd_i = src[rc[6:0]];

  spi_hdr_seq uut (.*);

  int checks = 0, failures = 0, cyc = 0;
  logic [95:0] cap;
  int cap_n, dum, pops, dones, pushes;
  logic [31:0] pw [4];
  logic psclk = 0;

  always @(negedge clk) begin
    cyc++;
    if (sclk && !psclk) begin
      case (sd_oe)
        4'h1: begin cap = {cap[94:0], sd_o[0]};   cap_n += 1; end
        4'h3: begin cap = {cap[93:0], sd_o[1:0]}; cap_n += 2; end
        4'hF: begin cap = {cap[91:0], sd_o};      cap_n += 4; end
        default: dum++;
      endcase
      rc++;
    end
    psclk = sclk;
    if (wf_pop) pops++;
    if (done) dones++;
    if (rf_push) begin pw[pushes[1:0]] = rf_data; pushes++; end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap = '0; cap_n = 0; dum = 0; pops = 0; dones = 0; pushes = 0; rc = 0;
    wq_rd = 0; wq_n = 0;
    for (int i = 0; i < 4; i++) pw[i] = '0;
    for (int i = 0; i < 128; i++) src[i] = 4'hF;
  endtask

  task automatic pulse_go();
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 4000 && !(busy && xfer_rdy); i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] cfg; logic [31:0] ins; logic [31:0] adr; logic [31:0] rmd;
    logic [31:0] wd; logic [1:0] pins; logic aq; logic [95:0] exp; int nb; int dm;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{16'h0001, 32'h0000009F, 32'h0, 32'h0, 32'h44332211, 2'b00, 1'b0,
      96'h9F11223344, 5, 0},
    '{16'h0031, 32'h00000002, 32'h00ABCDEF, 32'h0, 32'hDEADBEEF, 2'b00, 1'b0,
      96'h02ABCDEFEFBEADDE, 8, 0},
    '{16'h1020, 32'h0, 32'h00001234, 32'h0, 32'h87654321, 2'b01, 1'b0,
      96'h123421436587, 6, 8},
    '{16'h0151, 32'h0000006B, 32'h01020304, 32'h000000A5, 32'h0F0E0D0C, 2'b10, 1'b1,
      96'h6B0001020304A50C0D0E0F, 11, 0}
  };

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && sd_oe == 0 && !busy && xfer_rdy, "R1 reset state",
        {cs_n, sclk, sd_oe, busy, xfer_rdy}, {1'b1, 1'b0, 4'h0, 1'b0, 1'b1});

    for (int v = 0; v < 4; v++) begin
      clear_mon();
      wr_mode = 1; word4 = 1; hdr_cnt = VEC[v].cfg; inst_reg = VEC[v].ins;
      addr_reg = VEC[v].adr; rmode_reg = VEC[v].rmd; data_pins = VEC[v].pins;
      addr_quad = VEC[v].aq; wq[0] = VEC[v].wd; wq_n = 1;
      pulse_go();
      @(negedge clk);
      chk(busy && !xfer_rdy && !cs_n, "R10 busy header not ready", {busy, xfer_rdy}, 2'b10);
      wait_drained();
      repeat (40) @(negedge clk);
      chk(busy && !sclk, "R7 write holds until stop", {busy, sclk}, 2'b10);
      stop = 1;
      wait_idle();
      @(negedge clk) stop = 0;
      chk(cap_n == 8 * VEC[v].nb && cap == VEC[v].exp, "R2 R3 R5 R6 serial stream",
          cap, VEC[v].exp);
      chk(dum == VEC[v].dm, "R4 dummy clocks", dum, VEC[v].dm);
      chk(pops == 1 && dones == 1 && cs_n, "R9 one pop one done",
          {pops[7:0], dones[7:0]}, 16'h0101);
    end

    // R7: stop during a word lets the whole word go out
    clear_mon();
    hdr_cnt = 0; data_pins = 0; addr_quad = 0;
    wq[0] = 32'h55AA33CC; wq[1] = 32'h11111111; wq_n = 2;
    pulse_go();
    for (int i = 0; i < 4000 && cap_n < 8; i++) @(negedge clk);
    stop = 1;
    wait_idle();
    @(negedge clk) stop = 0;
    chk(cap_n == 32 && cap[31:0] == 32'hCC33AA55, "R7 late stop finishes word",
        cap, 96'hCC33AA55);
    chk(pops == 1, "R7 no pop after stop", pops, 1);

    // R6: one-byte words
    clear_mon();
    word4 = 0; wq[0] = 32'hFFFFFFA7; wq[1] = 32'h000000B8; wq_n = 2;
    pulse_go();
    wait_drained();
    stop = 1;
    wait_idle();
    @(negedge clk) stop = 0;
    chk(cap_n == 16 && cap[15:0] == 16'hA7B8, "R6 byte mode stream", cap, 96'hA7B8);
    chk(pops == 2, "R6 byte mode pops", pops, 2);

    // R8 R4: single-lane read with opcode and dummy
    clear_mon();
    wr_mode = 0; word4 = 1; hdr_cnt = 16'h1001; inst_reg = 32'h03; din_cnt = 6;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++)
        src[16 + 8 * k + j] = {2'b11, 8'(8'hA1 + k) >> (7 - j) & 8'h1, 1'b1} ;
    pulse_go();
    wait_idle();
    repeat (2) @(negedge clk);
    chk(!busy && dones == 1, "R8 read ends without stop", {busy, dones[0]}, 2'b01);
    chk(cap_n == 8 && cap[7:0] == 8'h03, "R5 opcode single lane", cap, 96'h03);
    chk(pushes == 2 && pw[0] == 32'hA4A3A2A1, "R8 R4 first word", pw[0], 32'hA4A3A2A1);
    chk(pw[1] == 32'h0000A6A5, "R8 partial word zero-filled", pw[1], 32'h0000A6A5);

    // R5 R8: quad read, one-byte words
    clear_mon();
    word4 = 0; hdr_cnt = 0; data_pins = 2'b10; din_cnt = 2;
    src[0] = 4'h5; src[1] = 4'hC; src[2] = 4'h3; src[3] = 4'hE;
    pulse_go();
    wait_idle();
    repeat (2) @(negedge clk);
    chk(pushes == 2 && pw[0] == 32'h5C && pw[1] == 32'h3E, "R5 R8 quad byte read",
        {pw[0], pw[1]}, {32'h5C, 32'h3E});
    chk(rc == 4, "R5 quad clock count", rc, 4);

    // R8: zero read count ends after header
    clear_mon();
    hdr_cnt = 16'h0001; inst_reg = 32'h66; din_cnt = 0; data_pins = 0;
    pulse_go();
    wait_idle();
    repeat (2) @(negedge clk);
    chk(pushes == 0 && dones == 1 && cap[7:0] == 8'h66 && cap_n == 8,
        "R8 zero count", {pushes[7:0], dones[7:0]}, 16'h0001);
    chk(xfer_rdy && cs_n && !sclk, "R1 R10 idle after read", {xfer_rdy, cs_n, sclk}, 3'b110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule